// File: doc/BRIEF.md
# ASCII Fixed-Point Distance Frame Decoder

This block consumes a byte stream, typically the output of a serial receive buffer, and picks out fixed eight-byte messages. Each message carries a distance written as ASCII text with one integer digit and three fractional digits. The decoder checks every byte against the layout that its position demands. It accumulates the four digits into a binary count of thousandths and, once the closing byte is accepted, presents that count with a one-cycle valid pulse.

The message layout is fixed. Position 0 holds 0x02 (start marker) and position 1 the integer digit. Position 2 holds 0x2E (the '.' character), and positions 3 to 5 hold the tenths, hundredths and thousandths digits. Position 6 holds 0x0D (carriage return) and position 7 holds 0x03 (end marker). A digit is any byte from 0x30 to 0x39. A frame that breaks this layout is dropped and counted in a saturating error counter. The decoder then hunts for the next start marker. A start marker inside a frame abandons the current frame and opens a new one. Nothing is retried.

Top module: `fxp_frame_parser`

## Requirements
- R1: After reset, out_valid is 0, err_count is 0 and the decoder is hunting for a start marker.
- R2: For a well-formed frame with digits a, b, c and d in positions 1, 3, 4 and 5, out_value equals a*1000 + b*100 + c*10 + d. out_valid is 1 for exactly one cycle, namely the cycle after the clock edge that accepts the end byte (0x03).
- R3: While the decoder is hunting, any byte other than 0x02 is dropped. It changes neither err_count nor out_valid.
- R4: A byte outside 0x30..0x39 in a digit position (1, 3, 4 or 5) raises err_count by one and drops the frame.
- R5: A byte other than 0x2E in position 2, other than 0x0D in position 6, or other than 0x03 in position 7 raises err_count by one and drops the frame.
- R6: After an error, bytes are dropped without any further count until a 0x02 byte arrives.
- R7: A 0x02 byte in positions 1 to 7 raises err_count by one. The same byte is taken as position 0 of a new frame.
- R8: A complete frame whose value exceeds 3000 thousandths raises err_count by one and produces no out_valid pulse.
- R9: err_count is 16 bits wide and holds at 65535 once it reaches that value.
- R10: A cycle with in_valid low consumes no byte, so gaps between the bytes of a frame do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Received byte |
| in_valid | input | 1 | in_byte is consumed on this clock edge |
| out_value | output | 12 | Decoded distance in thousandths |
| out_valid | output | 1 | One-cycle strobe marking a new out_value |
| err_count | output | 16 | Saturating count of malformed frames |

## Verification
The error count and the start of a new frame can fall on the same byte, when a start marker arrives in the middle of a frame. The bench provokes this by breaking a frame off with 0x02 and following it with a complete frame. It judges the result from two things: the error count rises by exactly one, and the following frame decodes to its own value through the scoreboard. The saturation test drives a long run of back-to-back start markers. Every one of them both counts an error and restarts the frame. The count must then stop at its maximum while the next good frame still decodes.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

    localparam logic [7:0] BYTE_SOF   = 8'h02;
    localparam logic [7:0] BYTE_EOF   = 8'h03;
    localparam logic [7:0] BYTE_CR    = 8'h0D;
    localparam logic [7:0] BYTE_POINT = 8'h2E;
    localparam logic [7:0] BYTE_ZERO  = 8'h30;
    localparam logic [7:0] BYTE_NINE  = 8'h39;

    // four decimal digits need up to 9999
    localparam int ACC_W = 14;

    typedef enum logic [2:0] {
        S_HUNT,
        S_ONES,
        S_POINT,
        S_TENTHS,
        S_HUNDREDTHS,
        S_THOUSANDTHS,
        S_CR,
        S_EOF
    } slot_e;

    typedef struct packed {
        logic       sof;
        logic       eof;
        logic       cr;
        logic       point;
        logic       digit;
        logic [3:0] nibble;
    } byte_kind_t;

    function automatic logic [ACC_W-1:0] times_ten_plus(
        input logic [ACC_W-1:0] a,
        input logic [3:0]       d
    );
        return (a << 3) + (a << 1) + {{(ACC_W-4){1'b0}}, d};
    endfunction

endpackage

// File: rtl/fxp_byte_class.sv
module fxp_byte_class
    import fxp_pkg::*;
(
    input  logic [7:0] byte_in,
    output byte_kind_t kind
);
    always_comb begin
        kind.sof    = (byte_in == BYTE_SOF);
        kind.eof    = (byte_in == BYTE_EOF);
        kind.cr     = (byte_in == BYTE_CR);
        kind.point  = (byte_in == BYTE_POINT);
        kind.digit  = (byte_in >= BYTE_ZERO) && (byte_in <= BYTE_NINE);
        kind.nibble = byte_in[3:0];
    end
endmodule

// File: rtl/fxp_err_sat.sv
module fxp_err_sat #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (bump && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

    // R9
    err_hold_max_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == TOP) |=> (cnt_q == TOP));

    // R9
    err_no_decrease_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q >= $past(cnt_q)));

    // R4
    err_step_one_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1)));
endmodule

// File: rtl/fxp_frame_seq.sv
module fxp_frame_seq
    import fxp_pkg::*;
#(
    parameter int MAX_MILLI = 3000,
    parameter int VAL_W     = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  byte_kind_t       kind,
    output logic             bad_frame,
    output logic [VAL_W-1:0] value,
    output logic             value_vld
);
    localparam logic [ACC_W-1:0] MAX_ACC = ACC_W'(MAX_MILLI);

    slot_e            slot_q, slot_n;
    logic [ACC_W-1:0] acc_q, acc_n;
    logic [VAL_W-1:0] val_q;
    logic             vld_q;
    logic             done;

    always_comb begin
        slot_n    = slot_q;
        acc_n     = acc_q;
        bad_frame = 1'b0;
        done      = 1'b0;
        if (take) begin
            if (kind.sof) begin
                bad_frame = (slot_q != S_HUNT);
                slot_n    = S_ONES;
                acc_n     = '0;
            end else begin
                case (slot_q)
                    S_HUNT: slot_n = S_HUNT;
                    S_ONES, S_TENTHS, S_HUNDREDTHS, S_THOUSANDTHS: begin
                        if (kind.digit) begin
                            acc_n = times_ten_plus(acc_q, kind.nibble);
                            case (slot_q)
                                S_ONES:       slot_n = S_POINT;
                                S_TENTHS:     slot_n = S_HUNDREDTHS;
                                S_HUNDREDTHS: slot_n = S_THOUSANDTHS;
                                default:      slot_n = S_CR;
                            endcase
                        end else begin
                            bad_frame = 1'b1;
                            slot_n    = S_HUNT;
                        end
                    end
                    S_POINT: begin
                        slot_n    = kind.point ? S_TENTHS : S_HUNT;
                        bad_frame = !kind.point;
                    end
                    S_CR: begin
                        slot_n    = kind.cr ? S_EOF : S_HUNT;
                        bad_frame = !kind.cr;
                    end
                    S_EOF: begin
                        slot_n = S_HUNT;
                        if (kind.eof && (acc_q <= MAX_ACC)) begin
                            done = 1'b1;
                        end else begin
                            bad_frame = 1'b1;
                        end
                    end
                    default: slot_n = S_HUNT;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= S_HUNT;
            acc_q  <= '0;
            val_q  <= '0;
            vld_q  <= 1'b0;
        end else begin
            slot_q <= slot_n;
            acc_q  <= acc_n;
            vld_q  <= done;
            if (done) begin
                val_q <= acc_q[VAL_W-1:0];
            end
        end
    end

    assign value     = val_q;
    assign value_vld = vld_q;

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> !vld_q);

    // R8
    value_range_chk: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> (val_q <= MAX_ACC[VAL_W-1:0]));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> ($stable(slot_q) && $stable(acc_q) && !vld_q));

    // R7
    sof_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (take && kind.sof) |=> (slot_q == S_ONES && acc_q == '0));
endmodule

// File: rtl/fxp_frame_parser.sv
module fxp_frame_parser
    import fxp_pkg::*;
#(
    parameter int MAX_MILLI = 3000,
    parameter int ERR_W     = 16,
    localparam int VAL_W    = $clog2(MAX_MILLI + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       in_byte,
    input  logic             in_valid,
    output logic [VAL_W-1:0] out_value,
    output logic             out_valid,
    output logic [ERR_W-1:0] err_count
);
    byte_kind_t kind;
    logic       bad_frame;

    fxp_byte_class u_class (
        .byte_in (in_byte),
        .kind    (kind)
    );

    fxp_frame_seq #(
        .MAX_MILLI (MAX_MILLI),
        .VAL_W     (VAL_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .take      (in_valid),
        .kind      (kind),
        .bad_frame (bad_frame),
        .value     (out_value),
        .value_vld (out_valid)
    );

    fxp_err_sat #(
        .CNT_W (ERR_W)
    ) u_err (
        .clk   (clk),
        .rst   (rst),
        .bump  (bad_frame),
        .count (err_count)
    );

    // R3
    hunt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
endmodule

// File: tb/fxp_frame_parser_bench.sv
module fxp_frame_parser_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  in_byte = 8'h00;
    logic        in_valid = 1'b0;
    logic [11:0] out_value;
    logic        out_valid;
    logic [15:0] err_count;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_err = 0;
    int exp_q[$];
    bit done_flag = 0;

    always #4 clk = ~clk;

    fxp_frame_parser u_fxp_frame_parser (
        .clk       (clk),
        .rst       (rst),
        .in_byte   (in_byte),
        .in_valid  (in_valid),
        .out_value (out_value),
        .out_valid (out_valid),
        .err_count (err_count)
    );

    // monitor: pops the scoreboard on each strobe
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2/R8: unexpected strobe value=%0d expected none", out_value);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(out_value) != e) begin
                    n_bad++;
                    $display("FAIL R2: value=%0d expected=%0d", out_value, e);
                end
            end
        end
    end

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_byte  = b;
        in_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic check_err(input string tag);
        n_cmp++;
        if (int'(err_count) != exp_err) begin
            n_bad++;
            $display("FAIL %s: err_count=%0d expected=%0d", tag, err_count, exp_err);
        end
    endtask

    // digits as characters; gap inserts idle cycles between bytes
    task automatic frame(input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] c, input logic [7:0] d,
                         input bit gap);
        int v;
        v = (int'(a) - 48) * 1000 + (int'(b) - 48) * 100 + (int'(c) - 48) * 10 + (int'(d) - 48);
        if (v <= 3000) exp_q.push_back(v);
        else exp_err++;
        put(8'h02); if (gap) idle(2);
        put(a);     if (gap) idle(3);
        put(8'h2E); if (gap) idle(1);
        put(b);     if (gap) idle(2);
        put(c);
        put(d);     if (gap) idle(4);
        put(8'h0D);
        put(8'h03);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: out_valid=%0b expected=0", out_valid);
        end
        check_err("R1");

        // R2 several values, back to back
        frame("1", "2", "3", "4", 0);
        frame("0", "0", "0", "0", 0);
        frame("3", "0", "0", "0", 0);
        frame("2", "5", "0", "9", 0);
        idle(2);
        check_err("R2");

        // R10 gaps inside a frame
        frame("1", "7", "5", "0", 1);
        idle(2);
        check_err("R10");

        // R3 junk while hunting
        put("A"); put(8'h0D); put(8'h03); put(8'h2E); put("5");
        idle(2);
        check_err("R3");

        // R4 bad digit bytes
        put(8'h02); put("x"); idle(1); exp_err++; check_err("R4");
        put(8'h02); put("1"); put(8'h2E); put("5"); put(8'h3A); idle(1); exp_err++; check_err("R4");
        put(8'h02); put("0"); put(8'h2E); put("1"); put("2"); put(8'h2F); idle(1); exp_err++; check_err("R4");

        // R5 wrong fixed bytes
        put(8'h02); put("1"); put(","); idle(1); exp_err++; check_err("R5");
        put(8'h02); put("1"); put(8'h2E); put("1"); put("1"); put("1"); put(8'h0A); idle(1); exp_err++; check_err("R5");
        put(8'h02); put("1"); put(8'h2E); put("1"); put("1"); put("1"); put(8'h0D); put(8'h04); idle(1); exp_err++; check_err("R5");

        // R6 drop after error
        put(8'h02); put("Q"); exp_err++;
        put("1"); put(8'h2E); put("2"); put("3"); put("4"); put(8'h0D); put(8'h03);
        idle(2);
        check_err("R6");
        frame("0", "4", "2", "0", 0);
        idle(2);
        check_err("R6");

        // R7 start marker mid-frame: count and restart on same byte
        put(8'h02); put("1"); put(8'h2E); exp_err++;
        frame("2", "5", "0", "0", 0);
        idle(2);
        check_err("R7");

        // R8 above range
        frame("3", "0", "0", "1", 0);
        frame("9", "9", "9", "9", 0);
        idle(2);
        check_err("R8");

        // R9 saturation via a run of start markers
        put(8'h02);
        for (int i = 0; i < 65535; i++) put(8'h02);
        idle(1);
        exp_err = 65535;
        check_err("R9");
        put(8'h02); put("z"); idle(1);
        check_err("R9");
        put(8'h0D);
        frame("1", "0", "0", "1", 0);
        idle(2);
        check_err("R9");

        // R1 reset clears the count
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
        exp_err = 0;
        check_err("R1");

        // scoreboard drained
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: pending=%0d expected=0", exp_q.size());
        end

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule